// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits next to a small processor core. It gathers interrupt requests from a fixed set of sources, picks the winner by a fixed priority rank and presents the 16-bit address of the vector word the core must fetch. Each of the 32 priority ranks owns one word in the table at the top of the address space. Rank 31 is the reset entry at FFFEh and rank 0 is the lowest entry at FFC0h. Some ranks belong to one source, whose pending bit the controller holds and clears on acknowledge. Other ranks are shared by several status flags, and those flags stay set until software clears them at their source.

After a reset of any kind, the controller presents the reset entry. The core fetches that word and returns it together with the acknowledge. If the word is blank (FFFFh), the core is parked in its deepest low-power state and no vector is offered. Any other word lets the core run. While the core runs, any presented request also raises a wake signal, which pulls the core out of a low-power mode.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While booting, which covers the state after `rst` and after any reset cause, the vector output is valid with address FFFEh, `run_o` and `halt_o` are low, and no other request is presented.
- R2: An acknowledge during boot with a returned word other than FFFFh puts the block in the run state (`run_o`=1, `halt_o`=0).
- R3: An acknowledge during boot with the word FFFFh parks the block (`halt_o`=1, `run_o`=0). While parked, no vector is presented and `wake_o` stays low, whatever requests arrive.
- R4: Any bit of `rst_cause_i` returns the block to boot and discards all held single-source pending bits.
- R5: A presented rank s has address FFC0h + 2*s. With the default parameters the single sources map to ranks 29, 26, 25 and 21 (addresses FFFAh, FFF4h, FFF2h, FFEAh) for `ded_req_i` bits 0 to 3. The shared flags map to ranks 28, 28, 24, 24, 23, 22, 19 and 18 for `shr_flag_i` bits 0 to 7. The protected group uses rank 30 (FFFCh).
- R6: When several ranks are requested at once, only the highest rank is presented.
- R7: A single-source or shared request is presented only while `gie_i` and its own enable bit are both set. A held single-source pending bit survives while it is masked and appears once it is unmasked.
- R8: The protected group at rank 30 is presented when one of its flags is set together with that flag's own enable bit, regardless of `gie_i`. It is not presented when that enable bit is clear.
- R9: An acknowledge of a single-source rank clears its pending bit, and the next lower request is presented after that clock edge.
- R10: An acknowledge of a shared rank leaves it presented while any of its flags remains set. It goes away once the flags are cleared.
- R11: `wake_o` is high exactly when the core signals low power (`lpm_i`) while the block runs and a vector is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| rst_cause_i | input | 4 | Other reset causes (pin, watchdog expiry, key violation, spare) |
| boot_word_i | input | 16 | Word read from the reset entry, sampled with the boot acknowledge |
| lpm_i | input | 1 | Core is in a low-power mode |
| gie_i | input | 1 | Global enable for maskable requests |
| ded_req_i | input | 4 | Single-cycle event pulses of single-source ranks |
| ded_en_i | input | 4 | Enables of single-source ranks |
| shr_flag_i | input | 8 | Level flags of shared ranks |
| shr_en_i | input | 8 | Enables of shared flags |
| nmi_flag_i | input | 3 | Level flags of the protected group |
| nmi_en_i | input | 3 | Per-flag enables of the protected group |
| ack_i | input | 1 | Core has taken the presented vector |
| vec_addr_o | output | 16 | Address of the vector word to fetch (0 when invalid) |
| vec_valid_o | output | 1 | Vector address is valid |
| run_o | output | 1 | Core may execute |
| halt_o | output | 1 | Core is parked in the deepest low-power state |
| wake_o | output | 1 | Request to leave a low-power mode |

## Verification
Every request and flag is registered once, so a pulse or a flag change becomes visible on `vec_addr_o` after the next rising edge. Enable and global-enable changes act at once, and they are also stable by that point. An acknowledge or a reset cause takes effect at the edge that samples it, and the new vector or state shows right after that edge. The bench drives every input on the falling edge and samples on the following falling edge, one rising edge later. This places each check in the first cycle where the expected value must hold, and a late or early update shows up as a mismatch.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    localparam int VEC_W     = 16;
    localparam int SLOT_W    = 5;
    localparam int NUM_SLOTS = 1 << SLOT_W;

    localparam logic [VEC_W-1:0]  TABLE_BASE = 16'hFFC0;
    localparam logic [VEC_W-1:0]  BLANK_WORD = 16'hFFFF;
    localparam logic [SLOT_W-1:0] BOOT_SLOT  = 5'd31;
    localparam logic [SLOT_W-1:0] PROT_SLOT  = 5'd30;

    typedef enum logic [1:0] {
        ST_BOOT = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } core_st_e;

    typedef struct packed {
        logic              vld;
        logic [SLOT_W-1:0] idx;
    } pick_t;

    function automatic logic [VEC_W-1:0] slot_addr(input logic [SLOT_W-1:0] s);
        return TABLE_BASE + {{(VEC_W-SLOT_W-1){1'b0}}, s, 1'b0};
    endfunction

endpackage

// File: rtl/ivc_req_collect.sv
module ivc_req_collect
    import ivc_pkg::*;
#(
    parameter int NUM_DED = 4,
    parameter int NUM_SHR = 8,
    parameter int NUM_NMI = 3,
    parameter logic [NUM_DED*SLOT_W-1:0] DED_SLOT = {5'd21, 5'd25, 5'd26, 5'd29},
    parameter logic [NUM_SHR*SLOT_W-1:0] SHR_SLOT = {5'd18, 5'd19, 5'd22, 5'd23,
                                                     5'd24, 5'd24, 5'd28, 5'd28}
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic                 gie,
    input  logic [NUM_DED-1:0]   ded_req,
    input  logic [NUM_DED-1:0]   ded_en,
    input  logic [NUM_SHR-1:0]   shr_flag,
    input  logic [NUM_SHR-1:0]   shr_en,
    input  logic [NUM_NMI-1:0]   nmi_flag,
    input  logic [NUM_NMI-1:0]   nmi_en,
    input  logic                 take,
    input  logic [SLOT_W-1:0]    take_slot,
    output logic [NUM_SLOTS-1:0] slot_req
);

    logic [NUM_DED-1:0] pend_q;
    logic [NUM_SHR-1:0] shr_q;
    logic [NUM_NMI-1:0] nmi_q;

    // held pending bits of single-source ranks
    for (genvar k = 0; k < NUM_DED; k++) begin : g_ded
        localparam logic [SLOT_W-1:0] MY_SLOT = DED_SLOT[k*SLOT_W +: SLOT_W];

        always_ff @(posedge clk) begin
            if (rst || flush) begin
                pend_q[k] <= 1'b0;
            end else if (ded_req[k]) begin
                pend_q[k] <= 1'b1;
            end else if (take && (take_slot == MY_SLOT)) begin
                pend_q[k] <= 1'b0;
            end
        end

        // R9
        ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
            (take && take_slot == MY_SLOT && !ded_req[k]) |=> !pend_q[k]);
    end

    // level flags are sampled once; software owns their clearing
    always_ff @(posedge clk) begin
        if (rst) begin
            shr_q <= '0;
            nmi_q <= '0;
        end else begin
            shr_q <= shr_flag;
            nmi_q <= nmi_flag;
        end
    end

    always_comb begin
        slot_req = '0;
        for (int k = 0; k < NUM_DED; k++) begin
            if (pend_q[k] && ded_en[k] && gie)
                slot_req[DED_SLOT[k*SLOT_W +: SLOT_W]] = 1'b1;
        end
        for (int j = 0; j < NUM_SHR; j++) begin
            if (shr_q[j] && shr_en[j] && gie)
                slot_req[SHR_SLOT[j*SLOT_W +: SLOT_W]] = 1'b1;
        end
        if (|(nmi_q & nmi_en))
            slot_req[PROT_SLOT] = 1'b1;
    end

    // R4
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (pend_q == '0));

endmodule

// File: rtl/ivc_prio_pick.sv
module ivc_prio_pick
    import ivc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SLOTS-1:0] req,
    output pick_t                pick
);

    always_comb begin
        pick = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (req[s]) begin
                pick.vld = 1'b1;
                pick.idx = SLOT_W'(s);
            end
        end
    end

    // R6
    pick_is_top_chk: assert property (@(posedge clk) disable iff (rst)
        pick.vld |-> ((req >> pick.idx) == NUM_SLOTS'(1)));

    // R6
    idle_means_none_chk: assert property (@(posedge clk) disable iff (rst)
        !pick.vld |-> (req == '0));

endmodule

// File: rtl/ivc_boot_fsm.sv
module ivc_boot_fsm
    import ivc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             ack,
    input  logic [VEC_W-1:0] boot_word,
    output core_st_e         st
);

    core_st_e st_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            st_q <= ST_BOOT;
        end else begin
            case (st_q)
                ST_BOOT: if (ack) st_q <= (boot_word == BLANK_WORD) ? ST_HALT : ST_RUN;
                ST_RUN:  st_q <= ST_RUN;
                ST_HALT: st_q <= ST_HALT;
                default: st_q <= ST_BOOT;
            endcase
        end
    end

    assign st = st_q;

    // R3
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HALT && !flush) |=> (st_q == ST_HALT));

    // R2
    boot_to_run_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_BOOT && ack && !flush && boot_word != BLANK_WORD) |=> (st_q == ST_RUN));

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import ivc_pkg::*;
#(
    parameter int NUM_RST = 4,
    parameter int NUM_DED = 4,
    parameter int NUM_SHR = 8,
    parameter int NUM_NMI = 3,
    parameter logic [NUM_DED*SLOT_W-1:0] DED_SLOT = {5'd21, 5'd25, 5'd26, 5'd29},
    parameter logic [NUM_SHR*SLOT_W-1:0] SHR_SLOT = {5'd18, 5'd19, 5'd22, 5'd23,
                                                     5'd24, 5'd24, 5'd28, 5'd28}
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_RST-1:0] rst_cause_i,
    input  logic [VEC_W-1:0]   boot_word_i,
    input  logic               lpm_i,
    input  logic               gie_i,
    input  logic [NUM_DED-1:0] ded_req_i,
    input  logic [NUM_DED-1:0] ded_en_i,
    input  logic [NUM_SHR-1:0] shr_flag_i,
    input  logic [NUM_SHR-1:0] shr_en_i,
    input  logic [NUM_NMI-1:0] nmi_flag_i,
    input  logic [NUM_NMI-1:0] nmi_en_i,
    input  logic               ack_i,
    output logic [VEC_W-1:0]   vec_addr_o,
    output logic               vec_valid_o,
    output logic               run_o,
    output logic               halt_o,
    output logic               wake_o
);

    logic                 flush;
    logic                 take;
    logic [NUM_SLOTS-1:0] slot_req;
    pick_t                pick;
    core_st_e             st;

    assign flush = |rst_cause_i;

    ivc_boot_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .ack       (ack_i),
        .boot_word (boot_word_i),
        .st        (st)
    );

    ivc_req_collect #(
        .NUM_DED  (NUM_DED),
        .NUM_SHR  (NUM_SHR),
        .NUM_NMI  (NUM_NMI),
        .DED_SLOT (DED_SLOT),
        .SHR_SLOT (SHR_SLOT)
    ) u_collect (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .gie       (gie_i),
        .ded_req   (ded_req_i),
        .ded_en    (ded_en_i),
        .shr_flag  (shr_flag_i),
        .shr_en    (shr_en_i),
        .nmi_flag  (nmi_flag_i),
        .nmi_en    (nmi_en_i),
        .take      (take),
        .take_slot (pick.idx),
        .slot_req  (slot_req)
    );

    ivc_prio_pick u_pick (
        .clk  (clk),
        .rst  (rst),
        .req  (slot_req),
        .pick (pick)
    );

    assign take = ack_i && (st == ST_RUN) && pick.vld;

    always_comb begin
        vec_valid_o = 1'b0;
        vec_addr_o  = '0;
        case (st)
            ST_BOOT: begin
                vec_valid_o = 1'b1;
                vec_addr_o  = slot_addr(BOOT_SLOT);
            end
            ST_RUN: begin
                vec_valid_o = pick.vld;
                vec_addr_o  = pick.vld ? slot_addr(pick.idx) : '0;
            end
            default: begin
                vec_valid_o = 1'b0;
                vec_addr_o  = '0;
            end
        endcase
    end

    assign run_o  = (st == ST_RUN);
    assign halt_o = (st == ST_HALT);
    assign wake_o = lpm_i && run_o && pick.vld;

    // R1
    boot_vector_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_o && !halt_o) |-> (vec_valid_o && vec_addr_o == 16'hFFFE));

    // R8
    prot_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (run_o && slot_req[PROT_SLOT]) |-> (vec_valid_o && vec_addr_o == 16'hFFFC));

    // R3
    parked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        halt_o |-> (!vec_valid_o && !wake_o && !run_o));

    // R11
    wake_needs_vector_chk: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> (vec_valid_o && run_o && lpm_i));

endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  rst_cause_i;
    logic [15:0] boot_word_i;
    logic        lpm_i, gie_i, ack_i;
    logic [3:0]  ded_req_i, ded_en_i;
    logic [7:0]  shr_flag_i, shr_en_i;
    logic [2:0]  nmi_flag_i, nmi_en_i;
    logic [15:0] vec_addr_o;
    logic        vec_valid_o, run_o, halt_o, wake_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_vector_ctrl u_dut (
        .clk(clk), .rst(rst), .rst_cause_i(rst_cause_i), .boot_word_i(boot_word_i),
        .lpm_i(lpm_i), .gie_i(gie_i), .ded_req_i(ded_req_i), .ded_en_i(ded_en_i),
        .shr_flag_i(shr_flag_i), .shr_en_i(shr_en_i), .nmi_flag_i(nmi_flag_i),
        .nmi_en_i(nmi_en_i), .ack_i(ack_i), .vec_addr_o(vec_addr_o),
        .vec_valid_o(vec_valid_o), .run_o(run_o), .halt_o(halt_o), .wake_o(wake_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one rising edge, then sample at the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_ded(input int k);
        ded_req_i[k] = 1'b1;
        step();
        ded_req_i[k] = 1'b0;
    endtask

    task automatic ack_once();
        ack_i = 1'b1;
        step();
        ack_i = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
        step();
        chk("R1 boot valid", {15'd0, vec_valid_o}, 16'd1);
        chk("R1 boot addr", vec_addr_o, 16'hFFFE);
        chk("R1 run low", {15'd0, run_o}, 16'd0);
        chk("R1 halt low", {15'd0, halt_o}, 16'd0);
        nmi_flag_i = 3'b001;
        nmi_en_i   = 3'b001;
        step();
        chk("R1 boot hides protected", vec_addr_o, 16'hFFFE);
        nmi_flag_i = 3'b000;
        nmi_en_i   = 3'b000;
        step();
    endtask

    task automatic t_boot_run();
        boot_word_i = 16'h1234;
        ack_once();
        chk("R2 run", {14'd0, run_o, halt_o}, 16'b10);
        chk("R2 no vector idle", {15'd0, vec_valid_o}, 16'd0);
    endtask

    task automatic t_single();
        gie_i    = 1'b1;
        ded_en_i = 4'hF;
        pulse_ded(0);
        chk("R5 rank29 addr", vec_addr_o, 16'hFFFA);
        ack_once();
        chk("R9 cleared", {15'd0, vec_valid_o}, 16'd0);
    endtask

    task automatic t_prio();
        shr_en_i      = 8'hFF;
        ded_req_i     = 4'b1010;
        shr_flag_i[4] = 1'b1;
        step();
        ded_req_i = 4'b0000;
        chk("R6 highest rank26", vec_addr_o, 16'hFFF4);
        ack_once();
        chk("R9 next is rank23", vec_addr_o, 16'hFFEE);
        ack_once();
        chk("R10 shared stays", vec_addr_o, 16'hFFEE);
        shr_flag_i[4] = 1'b0;
        step();
        chk("R10 shared gone, rank21", vec_addr_o, 16'hFFEA);
        ack_once();
        chk("R9 all clear", {15'd0, vec_valid_o}, 16'd0);
    endtask

    task automatic t_mask();
        gie_i = 1'b0;
        pulse_ded(2);
        chk("R7 gie masks", {15'd0, vec_valid_o}, 16'd0);
        gie_i = 1'b1;
        step();
        chk("R7 kept pending", vec_addr_o, 16'hFFF2);
        ded_en_i[2] = 1'b0;
        step();
        chk("R7 own enable masks", {15'd0, vec_valid_o}, 16'd0);
        ded_en_i[2] = 1'b1;
        step();
        ack_once();
        chk("R9 rank25 cleared", {15'd0, vec_valid_o}, 16'd0);
    endtask

    task automatic t_nmi();
        gie_i         = 1'b0;
        nmi_flag_i[1] = 1'b1;
        step();
        chk("R8 own enable off", {15'd0, vec_valid_o}, 16'd0);
        nmi_en_i[1] = 1'b1;
        step();
        chk("R8 bypasses gie", vec_addr_o, 16'hFFFC);
        pulse_ded(0);
        chk("R6 rank30 above 29", vec_addr_o, 16'hFFFC);
        ack_once();
        chk("R10 protected shared stays", vec_addr_o, 16'hFFFC);
        nmi_flag_i[1] = 1'b0;
        step();
        chk("R7 rank29 masked", {15'd0, vec_valid_o}, 16'd0);
        gie_i = 1'b1;
        step();
        chk("R7 rank29 unmasked", vec_addr_o, 16'hFFFA);
        ack_once();
        nmi_en_i = 3'b000;
    endtask

    task automatic t_wake();
        lpm_i = 1'b1;
        step();
        chk("R11 no request no wake", {15'd0, wake_o}, 16'd0);
        pulse_ded(1);
        chk("R11 wake", {15'd0, wake_o}, 16'd1);
        ack_once();
        chk("R11 wake drops", {15'd0, wake_o}, 16'd0);
        lpm_i = 1'b0;
    endtask

    task automatic t_cause();
        pulse_ded(3);
        chk("R5 rank21 addr", vec_addr_o, 16'hFFEA);
        rst_cause_i = 4'b0010;
        step();
        rst_cause_i = 4'b0000;
        chk("R4 back to boot", vec_addr_o, 16'hFFFE);
        chk("R4 not running", {15'd0, run_o}, 16'd0);
        boot_word_i = 16'h8000;
        ack_once();
        chk("R4 pending discarded", {15'd0, vec_valid_o}, 16'd0);
        chk("R2 running again", {15'd0, run_o}, 16'd1);
    endtask

    task automatic t_blank();
        rst_cause_i = 4'b0100;
        step();
        rst_cause_i = 4'b0000;
        boot_word_i = 16'hFFFF;
        ack_once();
        chk("R3 parked", {14'd0, run_o, halt_o}, 16'b01);
        lpm_i       = 1'b1;
        nmi_flag_i  = 3'b100;
        nmi_en_i    = 3'b100;
        pulse_ded(0);
        chk("R3 no vector parked", {15'd0, vec_valid_o}, 16'd0);
        chk("R3 no wake parked", {15'd0, wake_o}, 16'd0);
        step();
        chk("R3 stays parked", {15'd0, halt_o}, 16'd1);
    endtask

    initial begin
        rst = 1'b1; rst_cause_i = '0; boot_word_i = '0; lpm_i = 1'b0; gie_i = 1'b0;
        ack_i = 1'b0; ded_req_i = '0; ded_en_i = '0; shr_flag_i = '0; shr_en_i = '0;
        nmi_flag_i = '0; nmi_en_i = '0;
        @(negedge clk);
        t_reset();
        t_boot_run();
        t_single();
        t_prio();
        t_mask();
        t_nmi();
        t_wake();
        t_cause();
        t_blank();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule